// File: doc/BRIEF.md
# Mouse Motion Packet Queue

This block turns pointing-device events into five-byte motion packets and stores the bytes in a small circular queue. A host drains the queue one byte at a time. Each event gives a signed horizontal and vertical displacement and three button flags, and is offered with a one-cycle valid strobe. When the block is idle it accepts the event, latches the formatted packet and writes it into the queue at one byte per clock. While those writes are in progress the block raises `busy` and ignores any new event, so two packets never mix in the queue.

The first byte of a packet is a sync byte that carries the button states as active-low bits. The horizontal byte follows. The vertical byte comes next and has its sign flipped. Two zero bytes end the packet. Both motion bytes are clamped to a symmetric range of ±127. The host sees the byte at the head of the queue on `popData` while `byteAvail` is high, and removes it with `popReq`. A clear input empties the queue at any time.

Top module: `mouse_packet_queue`

## Requirements
- R1: An accepted event writes five bytes in this order: sync, X, Y, 0x00, 0x00. The writes take one byte per clock on the five clock edges that follow the acceptance edge.
- R2: The sync byte is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared when the middle button is pressed, and bit 0 cleared when the right button is pressed.
- R3: The X byte is the 8-bit two's complement of dx clamped to the range -127..+127. For example, -128 gives 0x81 and 300 gives 0x7F.
- R4: The Y byte is the 8-bit two's complement of -dy clamped to the range -127..+127. For example, dy=3 gives 0xFD and dy=-512 gives 0x7F.
- R5: An event is accepted when `evtValid` is high and `busy` is low. `busy` is high for exactly five cycles after acceptance. Events offered while `busy` is high are ignored.
- R6: A byte written to a full queue (QUEUE_DEPTH bytes held) is dropped. The bytes already stored and their order stay unchanged. A push and a pop in the same cycle on a full queue still drop the pushed byte.
- R7: While the queue is empty, `popData` reads 0x00 and `popReq` has no effect.
- R8: `byteAvail` is high exactly when the queue holds at least one byte. `popData` shows the oldest byte. `popReq` removes that byte, and `byteAvail` stays high while bytes remain.
- R9: The read and write positions wrap to zero at QUEUE_DEPTH, so byte order is kept across the wrap.
- R10: `queueClear` empties the queue, ends any packet still being written, and blocks acceptance of an event in the same cycle. It has priority over pushes and pops.
- R11: After reset the queue is empty, `busy` and `byteAvail` are low, and `popData` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Event strobe |
| evtDx | input | MOTION_W | Signed horizontal displacement |
| evtDy | input | MOTION_W | Signed vertical displacement |
| btnLeft | input | 1 | Left button pressed |
| btnMiddle | input | 1 | Middle button pressed |
| btnRight | input | 1 | Right button pressed |
| busy | output | 1 | Packet write in progress; events ignored |
| queueClear | input | 1 | Empty the queue and abort the packet |
| popReq | input | 1 | Remove the head byte |
| popData | output | 8 | Head byte, 0x00 when empty |
| byteAvail | output | 1 | Queue not empty |

## Verification
Events with no buttons pressed, each button pressed alone and all buttons pressed show whether each active-low bit is mapped to the right button. Motion values just inside the limit, exactly at the limit and far beyond it in both directions (including -128 and the most negative input) show whether the clamp is symmetric and whether Y is negated before it is clamped. A second event held high during a packet write, and a clear asserted in the middle of a write, show whether busy holds off new events and whether clear aborts the rest of the packet. A fourth packet pushed onto three stored ones, and repeated fill-and-drain rounds, show the partial-packet drop at full and the order of bytes across the pointer wrap.

// File: rtl/mpq_pkg.sv
`timescale 1ns/1ps
package mpq_pkg;
  localparam int PKT_BYTES = 5;
  localparam int IDX_W = $clog2(PKT_BYTES);
  localparam logic [7:0] SYNC_BASE = 8'h87;

  typedef struct packed {
    logic             loadEvt;
    logic             pushEn;
    logic [IDX_W-1:0] byteSel;
    logic             clearQ;
  } mpqCtrl_t;

  typedef enum logic { S_IDLE, S_PUSH } mpqState_e;
endpackage

// File: rtl/mpq_ctrl.sv
`timescale 1ns/1ps
module mpq_ctrl
  import mpq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     evtValid,
  input  logic     queueClear,
  output logic     busy,
  output mpqCtrl_t ctrl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

  mpqState_e        state;
  logic [IDX_W-1:0] idx;
  logic             accept;

  assign accept = evtValid && (state == S_IDLE) && !queueClear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
    end else if (queueClear) begin
      state <= S_IDLE;
      idx   <= '0;
    end else if (accept) begin
      state <= S_PUSH;
      idx   <= '0;
    end else if (state == S_PUSH) begin
      if (idx == LAST_IDX) begin
        state <= S_IDLE;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.loadEvt = accept;
    ctrl.pushEn  = (state == S_PUSH) && !queueClear;
    ctrl.byteSel = idx;
    ctrl.clearQ  = queueClear;
  end

  assign busy = (state == S_PUSH);
endmodule

// File: rtl/mpq_fifo.sv
`timescale 1ns/1ps
module mpq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic              notEmpty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop, isEmpty, isFull;

  assign isEmpty = (count == '0);
  assign isFull  = (count == CNT_FULL);
  assign doPush  = push && !isFull && !clr;
  assign doPop   = pop && !isEmpty && !clr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  assign popData  = isEmpty ? '0 : mem[rdPtr];
  assign notEmpty = !isEmpty;
endmodule

// File: rtl/mpq_datapath.sv
`timescale 1ns/1ps
module mpq_datapath
  import mpq_pkg::*;
#(
  parameter int MOTION_W    = 10,
  parameter int QUEUE_DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  mpqCtrl_t                   ctrl,
  input  logic signed [MOTION_W-1:0] evtDx,
  input  logic signed [MOTION_W-1:0] evtDy,
  input  logic                       btnLeft,
  input  logic                       btnMiddle,
  input  logic                       btnRight,
  input  logic                       popReq,
  output logic [7:0]                 popData,
  output logic                       byteAvail
);
  localparam int EXT_W = MOTION_W + 1;
  localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'(127);
  localparam logic signed [EXT_W-1:0] SAT_LO = EXT_W'(-127);

  logic signed [EXT_W-1:0]   xExt, yExt, yNeg;
  logic [7:0]                syncByte, xByte, yByte;
  logic [PKT_BYTES-1:0][7:0] pktReg;
  logic [PKT_BYTES-1:0][7:0] pktNext;
  logic [7:0]                pushData;

  function automatic logic [7:0] clampByte(input logic signed [EXT_W-1:0] v);
    if (v > SAT_HI)      return 8'h7F;
    else if (v < SAT_LO) return 8'h81;
    else                 return v[7:0];
  endfunction

  always_comb begin
    xExt     = EXT_W'(evtDx);
    yExt     = EXT_W'(evtDy);
    yNeg     = -yExt;
    xByte    = clampByte(xExt);
    yByte    = clampByte(yNeg);
    syncByte = SYNC_BASE ^ {5'b0, btnLeft, btnMiddle, btnRight};
  end

  // byte slot 0 leaves first; slots beyond the motion bytes are zero padding
  for (genvar g = 0; g < PKT_BYTES; g++) begin : gSlot
    if (g == 0) begin : gSync
      assign pktNext[g] = syncByte;
    end else if (g == 1) begin : gX
      assign pktNext[g] = xByte;
    end else if (g == 2) begin : gY
      assign pktNext[g] = yByte;
    end else begin : gPad
      assign pktNext[g] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pktReg <= '0;
    else if (ctrl.loadEvt) pktReg <= pktNext;
  end

  assign pushData = pktReg[ctrl.byteSel];

  mpq_fifo #(
    .DEPTH (QUEUE_DEPTH),
    .DATA_W(8)
  ) u_fifo (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (ctrl.clearQ),
    .push    (ctrl.pushEn),
    .pushData(pushData),
    .pop     (popReq),
    .popData (popData),
    .notEmpty(byteAvail)
  );
endmodule

// File: rtl/mouse_packet_queue.sv
`timescale 1ns/1ps
module mouse_packet_queue
  import mpq_pkg::*;
#(
  parameter int MOTION_W    = 10,
  parameter int QUEUE_DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       evtValid,
  input  logic signed [MOTION_W-1:0] evtDx,
  input  logic signed [MOTION_W-1:0] evtDy,
  input  logic                       btnLeft,
  input  logic                       btnMiddle,
  input  logic                       btnRight,
  output logic                       busy,
  input  logic                       queueClear,
  input  logic                       popReq,
  output logic [7:0]                 popData,
  output logic                       byteAvail
);
  mpqCtrl_t ctrl;

  mpq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtValid  (evtValid),
    .queueClear(queueClear),
    .busy      (busy),
    .ctrl      (ctrl)
  );

  mpq_datapath #(
    .MOTION_W   (MOTION_W),
    .QUEUE_DEPTH(QUEUE_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .evtDx    (evtDx),
    .evtDy    (evtDy),
    .btnLeft  (btnLeft),
    .btnMiddle(btnMiddle),
    .btnRight (btnRight),
    .popReq   (popReq),
    .popData  (popData),
    .byteAvail(byteAvail)
  );
endmodule

// File: rtl/mpq_checker.sv
`timescale 1ns/1ps
module mpq_checker #(
  parameter int PKT_N = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       evtValid,
  input logic       queueClear,
  input logic       popReq,
  input logic       busy,
  input logic       byteAvail,
  input logic [7:0] popData
);
  logic [3:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       busyRun <= '0;
    else if (!busy)                  busyRun <= '0;
    else if (busyRun != 4'hF)        busyRun <= busyRun + 1'b1;
  end

  assert_empty_reads_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !byteAvail |-> popData == 8'h00);

  assert_accept_sets_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && !busy && !queueClear |=> busy);

  assert_busy_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyRun < 4'(PKT_N));

  assert_push_fills_R1: assert property (@(posedge clk) disable iff (!rstN)
    busy && !queueClear |=> byteAvail);

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    queueClear |=> !byteAvail && !busy);

  assert_no_spurious_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !byteAvail |=> !byteAvail);

  assert_no_loss_R6: assert property (@(posedge clk) disable iff (!rstN)
    byteAvail && !popReq && !queueClear |=> byteAvail);
endmodule

bind mouse_packet_queue mpq_checker #(.PKT_N(mpq_pkg::PKT_BYTES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtValid  (evtValid),
  .queueClear(queueClear),
  .popReq    (popReq),
  .busy      (busy),
  .byteAvail (byteAvail),
  .popData   (popData)
);

// File: tb/tb_mouse_packet_queue.sv
`timescale 1ns/1ps
module tb_mouse_packet_queue;
  localparam int MW = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic signed [MW-1:0] evtDx = '0;
  logic signed [MW-1:0] evtDy = '0;
  logic btnLeft = 1'b0, btnMiddle = 1'b0, btnRight = 1'b0;
  logic busy;
  logic queueClear = 1'b0;
  logic popReq = 1'b0;
  logic [7:0] popData;
  logic byteAvail;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mouse_packet_queue #(.MOTION_W(MW), .QUEUE_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtDx(evtDx), .evtDy(evtDy),
    .btnLeft(btnLeft), .btnMiddle(btnMiddle), .btnRight(btnRight), .busy(busy),
    .queueClear(queueClear), .popReq(popReq), .popData(popData), .byteAvail(byteAvail)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int clampVal(input int v);
    if (v > 127) return 8'h7F;
    if (v < -127) return 8'h81;
    return v & 8'hFF;
  endfunction

  function automatic int syncVal(input bit l, input bit m, input bit r);
    int s = 8'h87;
    if (l) s &= ~4;
    if (m) s &= ~2;
    if (r) s &= ~1;
    return s;
  endfunction

  task automatic sendEvent(input int dx, input int dy, input bit l, input bit m, input bit r);
    evtDx = MW'(dx); evtDy = MW'(dy);
    btnLeft = l; btnMiddle = m; btnRight = r;
    evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic popByte(input string req, input int exp);
    check({req, " avail"}, int'(byteAvail), 1);
    check(req, int'(popData), exp);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  task automatic popPacket(input string req, input int dx, input int dy,
                           input bit l, input bit m, input bit r);
    popByte({req, " sync R2"}, syncVal(l, m, r));
    popByte({req, " x R3"}, clampVal(dx));
    popByte({req, " y R4"}, clampVal(-dy));
    popByte({req, " pad R1"}, 0);
    popByte({req, " pad R1"}, 0);
  endtask

  task automatic testReset();
    check("R11 avail", int'(byteAvail), 0);
    check("R11 busy", int'(busy), 0);
    check("R11 data", int'(popData), 0);
  endtask

  task automatic testBasic();
    sendEvent(5, 3, 0, 0, 0);
    popPacket("R1 basic", 5, 3, 0, 0, 0);
    check("R8 empty after drain", int'(byteAvail), 0);
  endtask

  task automatic testButtons();
    sendEvent(1, -1, 1, 0, 0); popPacket("R2 left", 1, -1, 1, 0, 0);
    sendEvent(0, 0, 0, 1, 0);  popPacket("R2 middle", 0, 0, 0, 1, 0);
    sendEvent(-2, 2, 0, 0, 1); popPacket("R2 right", -2, 2, 0, 0, 1);
    sendEvent(7, 7, 1, 1, 1);  popPacket("R2 all", 7, 7, 1, 1, 1);
  endtask

  task automatic testSaturation();
    sendEvent(300, -300, 0, 0, 0);  popPacket("R3 R4 big", 300, -300, 0, 0, 0);
    sendEvent(-512, 511, 0, 0, 0);  popPacket("R3 R4 extreme", -512, 511, 0, 0, 0);
    sendEvent(127, -127, 0, 0, 0);  popPacket("R3 R4 edge", 127, -127, 0, 0, 0);
    sendEvent(-128, -512, 0, 0, 0); popPacket("R3 R4 minus128", -128, -512, 0, 0, 0);
  endtask

  task automatic testBusyHold();
    int n = 0;
    evtDx = MW'(9); evtDy = MW'(-4); btnLeft = 0; btnMiddle = 0; btnRight = 1;
    evtValid = 1'b1;
    @(negedge clk);
    evtDx = MW'(-33); evtDy = MW'(44); btnRight = 0; btnLeft = 1;
    for (int i = 0; i < 8; i++) begin
      if (busy) n++;
      if (i == 2) evtValid = 1'b0;
      @(negedge clk);
    end
    check("R5 busy cycles", n, 5);
    popPacket("R5 first only", 9, -4, 0, 0, 1);
    check("R5 second ignored", int'(byteAvail), 0);
  endtask

  task automatic testOverflow();
    sendEvent(1, 1, 0, 0, 0);
    sendEvent(2, 2, 0, 0, 0);
    sendEvent(3, 3, 0, 0, 0);
    sendEvent(4, 4, 1, 0, 0);
    popPacket("R6 p1", 1, 1, 0, 0, 0);
    popPacket("R6 p2", 2, 2, 0, 0, 0);
    popPacket("R6 p3", 3, 3, 0, 0, 0);
    popByte("R6 partial sync", syncVal(1, 0, 0));
    check("R6 rest dropped", int'(byteAvail), 0);
  endtask

  task automatic testEmptyPop();
    check("R7 empty data", int'(popData), 0);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    check("R7 still empty", int'(byteAvail), 0);
    check("R7 data zero", int'(popData), 0);
    sendEvent(-6, 8, 0, 1, 1);
    popPacket("R7 order kept", -6, 8, 0, 1, 1);
  endtask

  task automatic testWrap();
    for (int k = 0; k < 3; k++) begin
      sendEvent(10 + k, -k, 0, 0, 0);
      sendEvent(-20 - k, 2 * k, 1, 0, 1);
      popPacket("R9 wrap a", 10 + k, -k, 0, 0, 0);
      popPacket("R9 wrap b", -20 - k, 2 * k, 1, 0, 1);
    end
    check("R9 empty", int'(byteAvail), 0);
  endtask

  task automatic testClear();
    evtDx = MW'(50); evtDy = MW'(50); btnLeft = 0; btnMiddle = 0; btnRight = 0;
    evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 bytes before clear", int'(byteAvail), 1);
    queueClear = 1'b1;
    @(negedge clk);
    queueClear = 1'b0;
    check("R10 cleared", int'(byteAvail), 0);
    check("R10 not busy", int'(busy), 0);
    repeat (4) @(negedge clk);
    check("R10 remainder aborted", int'(byteAvail), 0);
    sendEvent(1, 0, 0, 0, 0);
    popPacket("R10 after clear", 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testButtons();
    testSaturation();
    testBusyHold();
    testOverflow();
    testEmptyPop();
    testWrap();
    testClear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule